// File: doc/BRIEF.md
# Packed 8-bit Vector Dot-Product Unit

This unit takes two 128-bit vectors, each holding sixteen byte lanes, and multiplies every byte of operand A by the byte of operand B at the same index. Operand B is meant to hold small non-negative values, 0 to 127. The products are then summed across neighbouring lanes in one of two ways. In the pairwise form, two products are summed into each of eight 16-bit result lanes. In the accumulating form, four products are summed into each of four 32-bit lanes, and the matching 32-bit lane of a third vector C is added.

The operation is picked by a 2-bit select. Bit 1 of the select chooses the result form and bit 0 chooses how the A bytes are read. When a B byte has its top bit set, the elaboration parameter `B_HIGH_SIGNED` fixes the outcome. When it is 1, that byte is read as a signed value. When it is 0, it is read as an unsigned value. The same choice holds for every lane and every cycle.

Operands are presented with `inValid` high. The packed result and `outValid` appear one clock later from a single register stage. Byte lane i occupies bits [8i+7:8i] of A and B. A 16-bit result lane k occupies bits [16k+15:16k]. A 32-bit result or C lane k occupies bits [32k+31:32k].

Top module: `vdot_unit`

## Requirements
- R1: With `opSel` = 2'b10, A bytes are read as two's complement and B bytes as unsigned. Result lane k (16 bits) is the product of byte lane 2k plus the product of byte lane 2k+1.
- R2: With `opSel` = 2'b11, the pairwise sum of R1 is formed with the A bytes read as unsigned.
- R3: With `opSel` = 2'b00, A bytes are read as two's complement. Result lane k (32 bits) is the sum of the products of byte lanes 4k to 4k+3, plus lane k of C.
- R4: With `opSel` = 2'b01, the accumulating sum of R3 is formed with the A bytes read as unsigned.
- R5: Every sum wraps modulo 2^16 in the pairwise form and modulo 2^32 in the accumulating form. No saturation is applied.
- R6: A B byte with bit 7 set counts as a value in the range -128..-1 when `B_HIGH_SIGNED` is 1, and as a value in the range 128..255 when it is 0.
- R7: `outValid` is high in exactly the cycle after the clock edge that samples `inValid` high. The matching result is on `outData` in that same cycle.
- R8: While `inValid` is low, `outData` keeps its last value, whatever happens on the operand inputs.
- R9: A synchronous active-high `rst` clears `outData` to zero and `outValid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and select are valid this cycle |
| opSel | input | 2 | Operation select (see R1-R4 encodings) |
| opA | input | 128 | Sixteen byte lanes, signed or unsigned |
| opB | input | 128 | Sixteen byte lanes, intended 0..127 |
| opC | input | 128 | Four 32-bit accumulator lanes |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outData | output | 128 | Registered packed result |

## Verification
Random operands under all four selects show that pairwise and accumulating sums, and signed and unsigned A, are each decoded apart. A bytes of all 0x7F and all 0x80 separate the signed reading of A from the unsigned reading at the lane extremes. B bytes of 0x80 are sent to two instances built with opposite `B_HIGH_SIGNED` values, so the two readings of B must give distinct results. Large A and B values with C lanes near 0xFFFFFFFF force the 32-bit carry to wrap. An idle cycle with changed operands shows that the output is held.

// File: rtl/vdot_pkg.sv
package vdot_pkg;
  typedef struct packed {
    logic loadEn;
    logic wideMode;
    logic aSigned;
  } ctrlStrobes_t;
endpackage

// File: rtl/vdot_ctrl.sv
module vdot_ctrl
  import vdot_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [1:0]   opSel,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes.loadEn   = inValid;
    strobes.wideMode = ~opSel[1];
    strobes.aSigned  = ~opSel[0];
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R7
  AST_VALID_SINGLE:  assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R7
  AST_VALID_RESET:   assert property (@(posedge clk) rst |=> !outValid); // R9
endmodule

// File: rtl/vdot_datapath.sv
module vdot_datapath
  import vdot_pkg::*;
#(
  parameter int LANES         = 16,
  parameter int ELEM_W        = 8,
  parameter int NARROW_W      = 16,
  parameter int WIDE_W        = 32,
  parameter bit B_HIGH_SIGNED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobes_t              strobes,
  input  logic [LANES*ELEM_W-1:0]   opA,
  input  logic [LANES*ELEM_W-1:0]   opB,
  input  logic [LANES*ELEM_W-1:0]   opC,
  output logic [LANES*ELEM_W-1:0]   result
);
  localparam int VEC_W  = LANES * ELEM_W;
  localparam int EXT_W  = ELEM_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int PAIRS  = VEC_W / NARROW_W;
  localparam int QUADS  = VEC_W / WIDE_W;
  localparam int PER_PAIR = LANES / PAIRS;
  localparam int PER_QUAD = LANES / QUADS;

  logic signed [PROD_W-1:0] prod [LANES];
  logic [VEC_W-1:0] narrowVec;
  logic [VEC_W-1:0] wideVec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ELEM_W-1:0] aLane, bLane;
    logic signed [EXT_W-1:0] aExt, bExt;
    assign aLane = opA[i*ELEM_W +: ELEM_W];
    assign bLane = opB[i*ELEM_W +: ELEM_W];
    assign aExt  = strobes.aSigned ? {aLane[ELEM_W-1], aLane} : {1'b0, aLane};
    if (B_HIGH_SIGNED) begin : g_bsig
      assign bExt = {bLane[ELEM_W-1], bLane};
    end else begin : g_buns
      assign bExt = {1'b0, bLane};
    end
    assign prod[i] = aExt * bExt;
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    always_comb begin
      logic [NARROW_W-1:0] acc;
      acc = '0;
      for (int j = 0; j < PER_PAIR; j++)
        acc = acc + NARROW_W'(prod[k*PER_PAIR + j]);
      narrowVec[k*NARROW_W +: NARROW_W] = acc;
    end
  end

  for (genvar k = 0; k < QUADS; k++) begin : g_quad
    always_comb begin
      logic [WIDE_W-1:0] acc;
      acc = opC[k*WIDE_W +: WIDE_W];
      for (int j = 0; j < PER_QUAD; j++)
        acc = acc + WIDE_W'(prod[k*PER_QUAD + j]);
      wideVec[k*WIDE_W +: WIDE_W] = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobes.loadEn) result <= strobes.wideMode ? wideVec : narrowVec;
  end

  AST_HOLD_IDLE:  assert property (@(posedge clk) disable iff (rst) !strobes.loadEn |=> $stable(result)); // R8
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (result == '0)); // R9
  AST_ZERO_B_NARROW: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadEn && !strobes.wideMode && opB == '0) |=> (result == '0)); // R1
  AST_ZERO_AB_WIDE: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadEn && strobes.wideMode && opA == '0) |=> (result == $past(opC))); // R3
endmodule

// File: rtl/vdot_unit.sv
module vdot_unit
  import vdot_pkg::*;
#(
  parameter bit B_HIGH_SIGNED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [1:0]   opSel,
  input  logic [127:0] opA,
  input  logic [127:0] opB,
  input  logic [127:0] opC,
  output logic         outValid,
  output logic [127:0] outData
);
  ctrlStrobes_t strobes;

  vdot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .strobes(strobes), .outValid(outValid)
  );

  vdot_datapath #(
    .LANES(16), .ELEM_W(8), .NARROW_W(16), .WIDE_W(32),
    .B_HIGH_SIGNED(B_HIGH_SIGNED)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .opA(opA), .opB(opB), .opC(opC), .result(outData)
  );
endmodule

// File: tb/vdot_unit_tb_top.sv
`timescale 1ns/1ps
module vdot_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [127:0] opA = '0, opB = '0, opC = '0;
  logic outValidS, outValidU;
  logic [127:0] outDataS, outDataU;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vdot_unit #(.B_HIGH_SIGNED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC), .outValid(outValidS), .outData(outDataS));

  vdot_unit #(.B_HIGH_SIGNED(1'b0)) dut_u (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC), .outValid(outValidU), .outData(outDataU));

  function automatic logic [127:0] model(logic [1:0] sel, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] c, bit hs);
    int p [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      int av, bv;
      av = !sel[0] ? int'($signed(a[i*8 +: 8])) : int'(a[i*8 +: 8]);
      bv = (hs && b[i*8+7]) ? int'($signed(b[i*8 +: 8])) : int'(b[i*8 +: 8]);
      p[i] = av * bv;
    end
    r = '0;
    if (sel[1]) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] s;
        s = 32'(p[2*k] + p[2*k+1]);
        r[k*16 +: 16] = s[15:0];
      end
    end else begin
      for (int k = 0; k < 4; k++)
        r[k*32 +: 32] = 32'(p[4*k] + p[4*k+1] + p[4*k+2] + p[4*k+3]) + c[k*32 +: 32];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Issue one operation; compare both instances one clock later.
  task automatic apply(logic [1:0] sel, logic [127:0] a, logic [127:0] b,
                       logic [127:0] c, string req);
    logic [127:0] expS, expU;
    @(negedge clk);
    opSel = sel; opA = a; opB = b; opC = c; inValid = 1'b1;
    expS = model(sel, a, b, c, 1'b1);
    expU = model(sel, a, b, c, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    check(outValidS && outValidU, {req, " R7 valid"}, {127'd0, outValidS}, 128'd1);
    check(outDataS == expS, {req, " hs=1"}, outDataS, expS);
    check(outDataU == expU, {req, " hs=0"}, outDataU, expU);
    @(negedge clk);
    check(!outValidS && !outValidU, "R7 single-cycle valid", {127'd0, outValidS}, 128'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(outDataS == '0 && outDataU == '0, "R9 data cleared", outDataS, '0);
    check(!outValidS && !outValidU, "R9 valid cleared", {127'd0, outValidS}, '0);
    rst = 1'b0;
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [127:0] a, b, c;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom} & {16{8'h7F}};
      c = {$urandom, $urandom, $urandom, $urandom};
      apply(2'b10, a, b, c, "R1 random");
      apply(2'b11, a, b, c, "R2 random");
      apply(2'b00, a, b, c, "R3 random");
      apply(2'b01, a, b, c, "R4 random");
    end
  endtask

  task automatic t_extremes();
    apply(2'b10, {16{8'h80}}, {16{8'h7F}}, '0, "R1 A=0x80");
    check(outDataS[15:0] == 16'h8100, "R1 lane -128*127*2", {112'd0, outDataS[15:0]}, 128'h8100);
    apply(2'b11, {16{8'h80}}, {16{8'h7F}}, '0, "R2 A=0x80");
    check(outDataS[15:0] == 16'h7F00, "R2 lane 128*127*2", {112'd0, outDataS[15:0]}, 128'h7F00);
    apply(2'b10, {16{8'h7F}}, {16{8'h7F}}, '0, "R1 A=0x7F");
    apply(2'b00, {16{8'h80}}, {16{8'h7F}}, {4{32'h0000_0010}}, "R3 A=0x80");
    check(outDataS[31:0] == 32'hFFFF_0210, "R3 lane -128*127*4+16", {96'd0, outDataS[31:0]}, 128'hFFFF0210);
    apply(2'b01, {16{8'h7F}}, {16{8'h7F}}, {4{32'h1}}, "R4 A=0x7F");
  endtask

  task automatic t_bhigh();
    apply(2'b10, {16{8'h01}}, {16{8'h80}}, '0, "R6 B=0x80");
    check(outDataS[15:0] == 16'hFF00, "R6 signed B lane", {112'd0, outDataS[15:0]}, 128'hFF00);
    check(outDataU[15:0] == 16'h0100, "R6 unsigned B lane", {112'd0, outDataU[15:0]}, 128'h0100);
    apply(2'b11, {16{8'hFF}}, {16{8'hFF}}, '0, "R6 B=0xFF");
    apply(2'b01, {16{8'h02}}, {16{8'hC0}}, {4{32'd1000}}, "R6 wide B=0xC0");
  endtask

  task automatic t_wrap();
    apply(2'b01, {16{8'hFF}}, {16{8'h7F}}, {4{32'hFFFF_FFFF}}, "R5 wide wrap");
    check(outDataS[31:0] == 32'h0001_FA03, "R5 wrap lane", {96'd0, outDataS[31:0]}, 128'h0001FA03);
    apply(2'b11, {16{8'hFF}}, {16{8'hFF}}, '0, "R5 narrow wrap");
    check(outDataU[15:0] == 16'hFC02, "R5 narrow lane 2*255*255", {112'd0, outDataU[15:0]}, 128'hFC02);
  endtask

  task automatic t_hold();
    logic [127:0] held;
    apply(2'b10, {16{8'h05}}, {16{8'h03}}, '0, "R8 setup");
    held = outDataS;
    @(negedge clk);
    opA = {16{8'h77}}; opB = {16{8'h11}}; opC = '1; opSel = 2'b01;
    repeat (3) @(negedge clk);
    check(outDataS == held, "R8 held while idle", outDataS, held);
    check(!outValidS, "R8 no valid while idle", {127'd0, outValidS}, '0);
  endtask

  initial begin
    t_reset();
    t_random();
    t_extremes();
    t_bhigh();
    t_wrap();
    t_hold();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule